// File: doc/BRIEF.md
# Display-Side Nibble Receiver

This block models the display end of a character-display parallel bus that runs either a full byte per strobe or two half-bytes per strobe. It watches the enable line, samples the data and register-select lines on the chosen enable edge, and keeps track of which bus width the display currently believes in. In half-byte mode it joins two consecutive half-bytes into one byte. In full-byte mode it delivers a byte on every strobe. Each completed byte is presented with its register-select bit on a one-cycle valid pulse.

The receiver decodes the interface-width command itself. A command byte whose upper half is 0x3 selects full-byte mode, and one whose upper half is 0x2 selects half-byte mode. Its half-byte pairing state is never cleared by a command boundary. A host that restarts after sending only an upper half therefore stays visibly misaligned until it sends a proper resynchronising sequence. This makes the block a reference for checking host start-up and recovery sequences. It also flags address-set commands (command bytes with bit 7 high) so that a bench can see when a stray half-byte has turned into an address write.

Top module: `lcd_nibble_rx`

## Requirements
- R1: During and after reset the receiver is in full-byte mode (`mode8_o`=1), expects an upper half (`phase_o`=0) and has `byte_vld_o`=0.
- R2: In full-byte mode every strobe yields one byte. With a 4-line bus the lines form bits 7:4 and bits 3:0 are zero. With an 8-line bus the lines are the byte.
- R3: In half-byte mode the first strobe stores an upper half and sets `phase_o`=1 without a byte. The second strobe yields {stored half, new half}, takes the register-select of that second strobe and clears `phase_o`. Half-bytes are taken from the upper four bus lines.
- R4: The pairing phase survives any command sequence. After an unpaired upper half, the next strobe completes that old byte as its lower half.
- R5: A completed byte with register-select 0 and bits 7:4 = 0x3 sets full-byte mode from the next strobe on, with `phase_o`=0.
- R6: A completed byte with register-select 0 and bits 7:4 = 0x2 sets half-byte mode from the next strobe on, with `phase_o`=0. Bits 3:0 do not affect the mode.
- R7: No other byte changes the mode. This includes bytes with register-select 1, whatever their value.
- R8: `cmd_addr_o` is high together with `byte_vld_o` exactly when the byte has register-select 0 and bit 7 set.
- R9: A strobe is an enable falling edge (default) seen between two clock samples. The bus is sampled at the clock edge that first sees enable low. `byte_vld_o` rises in the cycle after that edge and lasts one cycle, and no byte appears without a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Bus enable line |
| rs_i | input | 1 | Register-select line, 0 = command |
| bus_i | input | BUS_W | Data lines (4 or 8) |
| mode8_o | output | 1 | 1 = full-byte mode, 0 = half-byte mode |
| phase_o | output | 1 | 1 = holding an upper half, awaiting the lower |
| byte_o | output | 8 | Last completed byte |
| byte_rs_o | output | 1 | Register-select of the last completed byte |
| byte_vld_o | output | 1 | One-cycle pulse per completed byte |
| cmd_addr_o | output | 1 | Completed byte is an address-set command |

## Verification
The bench builds the receiver with `BUS_W`=4 and `LATCH_ON_FALL`=1. This is the narrow bus on which both width modes and the half-byte misalignment can be reached. In full-byte mode a single strobe of 0x2 carries the switch to half-byte mode. A host restart after an upper half of 0x8 can turn the first 0x3 of a resync burst into an address command, and the bench follows that case through the whole odd-count resync. The 8-line lane mapping is present only as the generate branch selected by `BUS_W`=8.

// File: rtl/lcdrx_pkg.sv
package lcdrx_pkg;

    localparam logic [3:0] WIDTH_CMD_WIDE   = 4'h3;
    localparam logic [3:0] WIDTH_CMD_NARROW = 4'h2;

    typedef struct packed {
        logic       mode8;
        logic       phase;
        logic [3:0] hi;
        logic [7:0] data;
        logic       rs;
        logic       vld;
        logic       addr;
    } rx_state_t;

    typedef struct packed {
        logic is_width;
        logic sel8;
        logic is_addr;
    } cmd_info_t;

endpackage

// File: rtl/lcdrx_strobe.sv
module lcdrx_strobe #(
    parameter bit LATCH_ON_FALL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic stb_o
);
    logic en_d, en_q;

    always_comb begin
        en_d = en_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= en_d;
    end

    generate
        if (LATCH_ON_FALL) begin : g_fall
            assign stb_o = en_q & ~en_i;
        end else begin : g_rise
            assign stb_o = ~en_q & en_i;
        end
    endgenerate
endmodule

// File: rtl/lcdrx_lanes.sv
module lcdrx_lanes #(
    parameter int BUS_W = 8
) (
    input  logic [BUS_W-1:0] bus_i,
    output logic [3:0]       nib_o,
    output logic [7:0]       wide_o
);
    localparam int NIB_TOP = BUS_W - 1;

    assign nib_o = bus_i[NIB_TOP -: 4];

    generate
        if (BUS_W == 8) begin : g_full
            assign wide_o = bus_i;
        end else if (BUS_W == 4) begin : g_narrow
            assign wide_o = {bus_i, 4'h0};
        end else begin : g_bad
            $error("lcdrx_lanes: BUS_W must be 4 or 8");
        end
    endgenerate
endmodule

// File: rtl/lcdrx_decode.sv
module lcdrx_decode
    import lcdrx_pkg::*;
(
    input  logic [7:0] byte_i,
    input  logic       rs_i,
    output cmd_info_t  info_o
);
    always_comb begin
        info_o.is_width = !rs_i && ((byte_i[7:4] == WIDTH_CMD_WIDE) ||
                                    (byte_i[7:4] == WIDTH_CMD_NARROW));
        info_o.sel8     = (byte_i[7:4] == WIDTH_CMD_WIDE);
        info_o.is_addr  = !rs_i && byte_i[7];
    end
endmodule

// File: rtl/lcdrx_assemble.sv
module lcdrx_assemble
    import lcdrx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stb_i,
    input  logic       rs_i,
    input  logic [3:0] nib_i,
    input  logic [7:0] wide_i,
    input  cmd_info_t  info_i,
    output logic [7:0] cand_o,
    output rx_state_t  st_o
);
    rx_state_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.vld  = 1'b0;
        s_d.addr = 1'b0;
        cand_o   = s_q.mode8 ? wide_i : {s_q.hi, nib_i};
        if (stb_i) begin
            if (!s_q.mode8 && !s_q.phase) begin
                s_d.hi    = nib_i;
                s_d.phase = 1'b1;
            end else begin
                s_d.data  = cand_o;
                s_d.rs    = rs_i;
                s_d.vld   = 1'b1;
                s_d.addr  = info_i.is_addr;
                s_d.phase = 1'b0;
                if (info_i.is_width) s_d.mode8 = info_i.sel8;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{mode8: 1'b1, phase: 1'b0, hi: 4'h0, data: 8'h00,
                     rs: 1'b0, vld: 1'b0, addr: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign st_o = s_q;
endmodule

// File: rtl/lcd_nibble_rx.sv
module lcd_nibble_rx
    import lcdrx_pkg::*;
#(
    parameter int BUS_W         = 8,
    parameter bit LATCH_ON_FALL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             rs_i,
    input  logic [BUS_W-1:0] bus_i,
    output logic             mode8_o,
    output logic             phase_o,
    output logic [7:0]       byte_o,
    output logic             byte_rs_o,
    output logic             byte_vld_o,
    output logic             cmd_addr_o
);
    logic       stb;
    logic [3:0] nib;
    logic [7:0] wide;
    logic [7:0] cand;
    cmd_info_t  info;
    rx_state_t  st;

    lcdrx_strobe #(.LATCH_ON_FALL(LATCH_ON_FALL)) u_strobe (
        .clk   (clk),
        .rst_n (rst_n),
        .en_i  (en_i),
        .stb_o (stb)
    );

    lcdrx_lanes #(.BUS_W(BUS_W)) u_lanes (
        .bus_i  (bus_i),
        .nib_o  (nib),
        .wide_o (wide)
    );

    lcdrx_decode u_decode (
        .byte_i (cand),
        .rs_i   (rs_i),
        .info_o (info)
    );

    lcdrx_assemble u_assemble (
        .clk    (clk),
        .rst_n  (rst_n),
        .stb_i  (stb),
        .rs_i   (rs_i),
        .nib_i  (nib),
        .wide_i (wide),
        .info_i (info),
        .cand_o (cand),
        .st_o   (st)
    );

    assign mode8_o    = st.mode8;
    assign phase_o    = st.phase;
    assign byte_o     = st.data;
    assign byte_rs_o  = st.rs;
    assign byte_vld_o = st.vld;
    assign cmd_addr_o = st.addr;
endmodule

// File: rtl/lcd_nibble_rx_chk.sv
module lcd_nibble_rx_chk #(
    parameter int BUS_W         = 8,
    parameter bit LATCH_ON_FALL = 1'b1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en_i,
    input logic             rs_i,
    input logic [BUS_W-1:0] bus_i,
    input logic             mode8_o,
    input logic             phase_o,
    input logic [7:0]       byte_o,
    input logic             byte_rs_o,
    input logic             byte_vld_o,
    input logic             cmd_addr_o
);
    // R9
    vld_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld_o |=> !byte_vld_o);

    // R9
    vld_after_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld_o |-> ($past(en_i) != LATCH_ON_FALL) && ($past(en_i, 2) == LATCH_ON_FALL));

    // R3
    narrow_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld_o && !$past(mode8_o)) |-> $past(phase_o));

    // R5
    mode_change_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mode8_o) |-> (byte_vld_o && !byte_rs_o &&
                               byte_o[7:5] == 3'b001 && mode8_o == byte_o[4]));

    // R6
    narrow_entry_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mode8_o) |-> !phase_o);

    // R2
    wide_no_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode8_o |-> !phase_o);

    // R8
    addr_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_addr_o |-> (byte_vld_o && !byte_rs_o && byte_o[7]));
endmodule

bind lcd_nibble_rx lcd_nibble_rx_chk #(.BUS_W(BUS_W), .LATCH_ON_FALL(LATCH_ON_FALL)) u_chk (.*);

// File: tb/lcd_nibble_rx_bench.sv
module lcd_nibble_rx_bench;
    localparam int BW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en_i = 1'b0;
    logic          rs_i = 1'b0;
    logic [BW-1:0] bus_i = '0;
    logic          mode8_o, phase_o, byte_rs_o, byte_vld_o, cmd_addr_o;
    logic [7:0]    byte_o;

    int    vectors = 0;
    int    fails = 0;
    bit    done = 0;
    string cur_req = "R1";

    logic [9:0] exp_q[$];
    logic       m8 = 1'b1;
    logic       ph = 1'b0;
    logic [3:0] hi = 4'h0;

    always #5 clk = ~clk;

    lcd_nibble_rx #(.BUS_W(BW), .LATCH_ON_FALL(1'b1)) u_lcd_nibble_rx (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .rs_i(rs_i), .bus_i(bus_i),
        .mode8_o(mode8_o), .phase_o(phase_o), .byte_o(byte_o),
        .byte_rs_o(byte_rs_o), .byte_vld_o(byte_vld_o), .cmd_addr_o(cmd_addr_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Monitor: pops one expected byte per valid pulse.
    always @(negedge clk) begin
        if (rst_n && byte_vld_o) begin
            if (exp_q.size() == 0) begin
                vectors++;
                fails++;
                $display("FAIL R9: actual unexpected byte %0h expected none", byte_o);
            end else begin
                check(cur_req, {cmd_addr_o, byte_rs_o, byte_o}, exp_q.pop_front());
            end
        end
    end

    // Driver: updates the reference model, pushes expectations, drives one strobe.
    task automatic send(input string req, input logic rs, input logic [3:0] n);
        logic [7:0] b;
        logic       complete;
        complete = 1'b0;
        b = 8'h00;
        if (m8) begin
            b = {n, 4'h0};
            complete = 1'b1;
        end else if (!ph) begin
            hi = n;
            ph = 1'b1;
        end else begin
            b = {hi, n};
            complete = 1'b1;
            ph = 1'b0;
        end
        if (complete) begin
            exp_q.push_back({(!rs && b[7]), rs, b});
            if (!rs && b[7:4] == 4'h3) m8 = 1'b1;
            else if (!rs && b[7:4] == 4'h2) m8 = 1'b0;
        end
        cur_req = req;
        @(negedge clk);
        rs_i = rs; bus_i = n; en_i = 1'b1;
        @(negedge clk);
        en_i = 1'b0;
        @(negedge clk);
        check({req, " mode"}, mode8_o, m8);
        check({req, " phase"}, phase_o, ph);
        @(negedge clk);
        check("R9 pulse end", byte_vld_o, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 mode", mode8_o, 1'b1);
        check("R1 phase", phase_o, 1'b0);
        check("R1 vld", byte_vld_o, 1'b0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R9 idle", byte_vld_o, 1'b0);

        // full-byte mode on a 4-line bus
        send("R2", 1'b1, 4'hA);
        send("R7", 1'b0, 4'h5);
        send("R8", 1'b0, 4'h9);
        // width command to half-byte mode
        send("R6", 1'b0, 4'h2);
        // ordinary pairs
        send("R3", 1'b1, 4'h4); send("R3", 1'b1, 4'h1);
        send("R8", 1'b0, 4'hC); send("R8", 1'b0, 4'h7);
        // data byte that looks like a width command
        send("R7", 1'b1, 4'h3); send("R7", 1'b1, 4'h0);
        // host restart after an upper half, then odd resync burst
        send("R4", 1'b0, 4'h8);
        send("R4", 1'b0, 4'h3);
        send("R5", 1'b0, 4'h3); send("R5", 1'b0, 4'h3);
        send("R5", 1'b0, 4'h3);
        send("R6", 1'b0, 4'h2);
        send("R6", 1'b0, 4'h2); send("R6", 1'b0, 4'h8);
        // width command to full-byte mode from a pair
        send("R5", 1'b0, 4'h3); send("R5", 1'b0, 4'h0);
        send("R2", 1'b1, 4'hF);
        // reset while an upper half is pending
        send("R6", 1'b0, 4'h2);
        send("R3", 1'b1, 4'h5);
        @(negedge clk);
        rst_n = 1'b0;
        m8 = 1'b1; ph = 1'b0;
        @(negedge clk);
        check("R1 mid mode", mode8_o, 1'b1);
        check("R1 mid phase", phase_o, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        send("R1", 1'b1, 4'h6);

        repeat (4) @(negedge clk);
        check("R9 queue empty", exp_q.size(), 0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule